// File: doc/BRIEF.md
# Sine-Slope ADSR Envelope Generator

This block keeps eight independent attack/decay/sustain/release envelopes and refreshes all of them on every sample tick, which a system timer raises at 10 kHz. The channels share one arithmetic path. After a tick, the sequencer updates channel 0, then channel 1, and so on, one channel per clock. For each channel it drives a valid strobe together with the channel number and the new 8-bit envelope value. Whatever sits downstream (scaling, mixing, converter drive) picks up the values from this stream.

Each channel has a 24-bit phase. The top eight bits of the phase select an entry on the rising quarter of a sine-like curve. The attack phase adds the channel's attack increment to the phase, which moves it up the curve. The decay and release phases subtract their own increments, which moves it back down the same curve. The envelope shape therefore comes from the table and not from a straight-line ramp. A new key press resumes the climb from the current phase instead of restarting at zero. A key release starts the descent from wherever the envelope is at that moment.

The gate-on and gate-off inputs are one-cycle pulses, one bit per channel. They are held internally until that channel's next update.

Top module: `env_sine_adsr`

## Requirements
- R1: After reset the strobe `env_vld_o` is low, `env_val_o` is 0, and every channel is idle with phase 0.
- R2: If `tick_i` is high at a clock edge while no burst is running, the next NCH edges each produce one strobed output, for channels 0 to NCH-1 in ascending order. The strobe is low at all other times, and `env_val_o` holds its value while the strobe is low. A tick that arrives during a burst is ignored.
- R3: The output value is T(i) = floor(i*(256-i)*255/16384), where i = phase[23:16], the table index. The index runs from 0 to 128, so T(0)=0, T(64)=191 and T(128)=255.
- R4: In attack, each update adds the attack increment to the phase. If the sum reaches or exceeds 0x800000 (index 128), the phase is clamped to 0x800000, the output is 255 and the channel moves to decay.
- R5: In decay, each update subtracts the decay increment. If the result is at or below the floor S*65536, where S is the sustain level limited to 128, the phase is set to the floor and the channel moves to sustain.
- R6: In sustain, the phase and the output stay constant until a gate event arrives.
- R7: In release, each update subtracts the release increment. If the result is zero or negative, the phase becomes 0, the output becomes 0 and the channel goes idle.
- R8: A gate-on puts the channel into attack from any state, including attack itself. The attack step is applied in that same update, starting from the current phase.
- R9: A gate-off in attack, decay or sustain puts the channel into release. The release step is applied in that same update, starting from the current phase. A release during attack therefore skips decay.
- R10: An idle channel outputs 0 and ignores gate-off.
- R11: A gate pulse is held until that channel's next update and is then consumed. If both a gate-on and a gate-off are pending, gate-on wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick; starts a burst of channel updates |
| gate_on_i | input | NCH | Per-channel key-press pulse |
| gate_off_i | input | NCH | Per-channel key-release pulse |
| rise_inc_i | input | NCH*PW | Per-channel attack increments, channel c at bits [c*PW +: PW] |
| fall_inc_i | input | NCH*PW | Per-channel decay increments |
| fade_inc_i | input | NCH*PW | Per-channel release increments |
| hold_lvl_i | input | NCH*8 | Per-channel sustain level, as a table index |
| env_vld_o | output | 1 | Output strobe |
| env_ch_o | output | clog2(NCH) | Channel number of the current output |
| env_val_o | output | 8 | Envelope value |

## Verification
Take the clock edge that samples `tick_i` as edge 0. The value for channel c is registered at edge c+1, and the strobe drops after edge NCH. The bench drives a tick one clock, then samples at the falling edge that follows each of the next NCH rising edges, expecting channel c at the (c+1)-th of those samples. It samples once more to confirm the strobe is low. Gate pulses are applied a fixed number of cycles before the tick, so the expected state of each channel, computed by a model of the requirements, already includes those events when the channel is updated.

// File: rtl/env_pkg.sv
package env_pkg;

    localparam int IDX_W   = 8;
    localparam int TBL_TOP = 128;

    typedef enum logic [2:0] {
        ENV_IDLE = 3'd0,
        ENV_RISE = 3'd1,
        ENV_FALL = 3'd2,
        ENV_HOLD = 3'd3,
        ENV_FADE = 3'd4
    } env_mode_e;

    // Quarter-wave curve: i*(256-i)*255/16384, rising from 0 at i=0 to 255 at i=128
    function automatic logic [IDX_W-1:0] slope_val(input logic [IDX_W-1:0] i);
        logic [22:0] p;
        p = 23'(i) * (23'd256 - 23'(i)) * 23'd255;
        return IDX_W'(p >> 14);
    endfunction

endpackage

// File: rtl/env_slope_lut.sv
module env_slope_lut
    import env_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] val_o
);

    assign val_o = slope_val(idx_i);

endmodule

// File: rtl/env_step.sv
module env_step
    import env_pkg::*;
#(
    parameter int PW = 24
) (
    input  env_mode_e        mode_i,
    input  logic [PW-1:0]    phase_i,
    input  logic [PW-1:0]    rise_inc_i,
    input  logic [PW-1:0]    fall_inc_i,
    input  logic [PW-1:0]    fade_inc_i,
    input  logic [IDX_W-1:0] hold_lvl_i,
    input  logic             on_i,
    input  logic             off_i,
    output env_mode_e        mode_o,
    output logic [PW-1:0]    phase_o
);

    localparam int          SH   = PW - IDX_W;
    localparam logic [PW:0] PEAK = (PW+1)'(TBL_TOP) << SH;

    env_mode_e        m;
    logic [IDX_W-1:0] lvl;
    logic [PW:0]      sum;
    logic [PW+1:0]    fall_diff;
    logic [PW+1:0]    fade_diff;
    logic [PW+1:0]    floor_v;

    always_comb begin
        m = mode_i;
        if (on_i) begin
            m = ENV_RISE;
        end else if (off_i && mode_i != ENV_IDLE) begin
            m = ENV_FADE;
        end

        lvl       = (hold_lvl_i > IDX_W'(TBL_TOP)) ? IDX_W'(TBL_TOP) : hold_lvl_i;
        sum       = {1'b0, phase_i} + {1'b0, rise_inc_i};
        fall_diff = {2'b00, phase_i} - {2'b00, fall_inc_i};
        fade_diff = {2'b00, phase_i} - {2'b00, fade_inc_i};
        floor_v   = (PW+2)'(lvl) << SH;

        mode_o  = m;
        phase_o = phase_i;

        unique case (m)
            ENV_RISE: begin
                if (sum >= PEAK) begin
                    phase_o = PEAK[PW-1:0];
                    mode_o  = ENV_FALL;
                end else begin
                    phase_o = sum[PW-1:0];
                end
            end
            ENV_FALL: begin
                if (fall_diff[PW+1] || fall_diff <= floor_v) begin
                    phase_o = floor_v[PW-1:0];
                    mode_o  = ENV_HOLD;
                end else begin
                    phase_o = fall_diff[PW-1:0];
                end
            end
            ENV_HOLD: begin
                phase_o = phase_i;
            end
            ENV_FADE: begin
                if (fade_diff[PW+1] || fade_diff == '0) begin
                    phase_o = '0;
                    mode_o  = ENV_IDLE;
                end else begin
                    phase_o = fade_diff[PW-1:0];
                end
            end
            default: begin
                phase_o = '0;
                mode_o  = ENV_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/env_sine_adsr.sv
module env_sine_adsr
    import env_pkg::*;
#(
    parameter int NCH = 8,
    parameter int PW  = 24,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic [NCH-1:0]       gate_on_i,
    input  logic [NCH-1:0]       gate_off_i,
    input  logic [NCH*PW-1:0]    rise_inc_i,
    input  logic [NCH*PW-1:0]    fall_inc_i,
    input  logic [NCH*PW-1:0]    fade_inc_i,
    input  logic [NCH*IDX_W-1:0] hold_lvl_i,
    output logic                 env_vld_o,
    output logic [CW-1:0]        env_ch_o,
    output logic [IDX_W-1:0]     env_val_o
);

    typedef struct packed {
        logic                      busy;
        logic [CW-1:0]             idx;
        logic [NCH-1:0]            pend_on;
        logic [NCH-1:0]            pend_off;
        logic [NCH-1:0][PW-1:0]    phase;
        env_mode_e [NCH-1:0]       mode;
        logic                      vld;
        logic [CW-1:0]             ch;
        logic [IDX_W-1:0]          val;
    } state_t;

    state_t           q, d;
    env_mode_e        step_mode;
    logic [PW-1:0]    step_phase;
    logic [IDX_W-1:0] lut_val;

    // Single shared update path, steered to the channel under service
    env_step #(.PW(PW)) u_step (
        .mode_i    (q.mode[q.idx]),
        .phase_i   (q.phase[q.idx]),
        .rise_inc_i(rise_inc_i[q.idx*PW +: PW]),
        .fall_inc_i(fall_inc_i[q.idx*PW +: PW]),
        .fade_inc_i(fade_inc_i[q.idx*PW +: PW]),
        .hold_lvl_i(hold_lvl_i[q.idx*IDX_W +: IDX_W]),
        .on_i      (q.pend_on[q.idx]),
        .off_i     (q.pend_off[q.idx]),
        .mode_o    (step_mode),
        .phase_o   (step_phase)
    );

    env_slope_lut u_lut (
        .idx_i(step_phase[PW-1 -: IDX_W]),
        .val_o(lut_val)
    );

    always_comb begin
        d          = q;
        d.vld      = 1'b0;
        d.pend_on  = q.pend_on | gate_on_i;
        d.pend_off = q.pend_off | gate_off_i;

        if (!q.busy) begin
            if (tick_i) begin
                d.busy = 1'b1;
                d.idx  = '0;
            end
        end else begin
            d.phase[q.idx]    = step_phase;
            d.mode[q.idx]     = step_mode;
            d.pend_on[q.idx]  = gate_on_i[q.idx];
            d.pend_off[q.idx] = gate_off_i[q.idx];
            d.vld             = 1'b1;
            d.ch              = q.idx;
            d.val             = lut_val;
            if (q.idx == CW'(NCH-1)) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign env_vld_o = q.vld;
    assign env_ch_o  = q.ch;
    assign env_val_o = q.val;

endmodule

// File: rtl/env_chk.sv
module env_chk #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic          env_vld_o,
    input logic [CW-1:0] env_ch_o,
    input logic [7:0]    env_val_o
);

    AST_CH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        env_vld_o |-> (int'(env_ch_o) < NCH)); // R2

    AST_CH_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (env_vld_o && $past(env_vld_o)) |-> (env_ch_o == CW'($past(env_ch_o) + 1'b1))); // R2

    AST_BURST_OPENS_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(env_vld_o) |-> (env_ch_o == '0)); // R2

    AST_BURST_CLOSES_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(env_vld_o) |-> (int'($past(env_ch_o)) == NCH-1)); // R2

    AST_BURST_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(env_vld_o) |-> $past(tick_i, 2)); // R2

    AST_VAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !env_vld_o |-> $stable(env_val_o)); // R2

endmodule

bind env_sine_adsr env_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .env_vld_o(env_vld_o),
    .env_ch_o (env_ch_o),
    .env_val_o(env_val_o)
);

// File: tb/test_env_sine_adsr.sv
module test_env_sine_adsr;

    localparam int NCH = 8;
    localparam int PW  = 24;
    localparam longint PEAK = 64'h800000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [NCH-1:0]    gate_on = '0;
    logic [NCH-1:0]    gate_off = '0;
    logic [NCH*PW-1:0] rise_inc = '0;
    logic [NCH*PW-1:0] fall_inc = '0;
    logic [NCH*PW-1:0] fade_inc = '0;
    logic [NCH*8-1:0]  hold_lvl = '0;
    logic              vld;
    logic [2:0]        ch;
    logic [7:0]        val;

    int n_chk = 0;
    int n_fail = 0;

    longint mphase[NCH];
    int     mmode[NCH];  // 0 idle, 1 attack, 2 decay, 3 sustain, 4 release
    bit     pon[NCH];
    bit     poff[NCH];
    longint rise[NCH];
    longint fall[NCH];
    longint fade[NCH];
    int     hold[NCH];
    int     obs[NCH];

    always #10 clk = ~clk;

    env_sine_adsr #(.NCH(NCH), .PW(PW)) i_env_sine_adsr (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .gate_on_i (gate_on),
        .gate_off_i(gate_off),
        .rise_inc_i(rise_inc),
        .fall_inc_i(fall_inc),
        .fade_inc_i(fade_inc),
        .hold_lvl_i(hold_lvl),
        .env_vld_o (vld),
        .env_ch_o  (ch),
        .env_val_o (val)
    );

    function automatic int curve(longint i);
        return int'((i * (256 - i) * 255) / 16384);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_params();
        for (int c = 0; c < NCH; c++) begin
            rise_inc[c*PW +: PW] = 24'(rise[c]);
            fall_inc[c*PW +: PW] = 24'(fall[c]);
            fade_inc[c*PW +: PW] = 24'(fade[c]);
            hold_lvl[c*8 +: 8]   = 8'(hold[c]);
        end
    endtask

    // Model of one channel update, built from R4..R11
    task automatic model_step(input int c, output int ev, output string tag);
        int     m = mmode[c];
        longint p = mphase[c];
        longint fl;
        tag = "";
        if (pon[c]) begin
            m = 1; tag = "R8";
        end else if (poff[c] && m != 0) begin
            m = 4; tag = "R9";
        end else if (poff[c]) begin
            tag = "R10";
        end
        pon[c] = 0;
        poff[c] = 0;
        case (m)
            1: begin
                p = p + rise[c];
                if (p >= PEAK) begin p = PEAK; m = 2; end
                if (tag == "") tag = "R4";
            end
            2: begin
                fl = longint'((hold[c] > 128) ? 128 : hold[c]) << 16;
                p = p - fall[c];
                if (p <= fl) begin p = fl; m = 3; end
                if (tag == "") tag = "R5";
            end
            3: if (tag == "") tag = "R6";
            4: begin
                p = p - fade[c];
                if (p <= 0) begin p = 0; m = 0; end
                if (tag == "") tag = "R7";
            end
            default: begin
                p = 0;
                if (tag == "") tag = "R10";
            end
        endcase
        mmode[c] = m;
        mphase[c] = p;
        ev = curve(p >> 16);
    endtask

    task automatic burst(input logic [NCH-1:0] on_m, input logic [NCH-1:0] off_m,
                         input int lead, input string force_tag, input bit mid_tick);
        int    ev;
        string tag;
        @(negedge clk);
        gate_on = on_m;
        gate_off = off_m;
        @(negedge clk);
        gate_on = '0;
        gate_off = '0;
        for (int c = 0; c < NCH; c++) begin
            if (on_m[c]) pon[c] = 1;
            if (off_m[c]) poff[c] = 1;
        end
        repeat (lead) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            model_step(k, ev, tag);
            if (force_tag != "") tag = force_tag;
            chk(vld === 1'b1 && int'(ch) == k, "R2", "strobed channel", longint'(ch), k);
            chk(val === 8'(ev), tag, $sformatf("value ch%0d", k), longint'(val), ev);
            obs[k] = int'(val);
            if (mid_tick && k == 2) tick = 1'b1;
            if (mid_tick && k == 3) tick = 1'b0;
        end
        @(negedge clk);
        chk(vld === 1'b0, "R2", "strobe low after burst", longint'(vld), 0);
        if (mid_tick) begin
            repeat (3) begin
                @(negedge clk);
                chk(vld === 1'b0, "R2", "tick during burst ignored", longint'(vld), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NCH-1:0] on_m, off_m;
        void'($urandom(32'd7331));
        for (int c = 0; c < NCH; c++) begin
            mphase[c] = 0; mmode[c] = 0; pon[c] = 0; poff[c] = 0;
            rise[c] = 64'h040000; fall[c] = 64'h030000; fade[c] = 64'h020000; hold[c] = 64;
        end
        rise[0] = 64'h010000; fall[0] = 64'h080000; hold[0] = 96;
        rise[1] = 64'h020000;
        hold[2] = 200;
        drive_params();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(vld === 1'b0, "R1", "strobe in reset", longint'(vld), 0);
        chk(val === 8'd0, "R1", "value in reset", longint'(val), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R10: all channels idle output 0
        burst('0, '0, 0, "R1", 1'b0);
        // R3: sweep ch0 one index per tick over the whole curve, others start too
        burst(8'hFF, '0, 0, "R3", 1'b0);
        for (int t = 1; t < 130; t++) begin
            burst('0, '0, 0, "", 1'b0);
            if (t == 63) chk(obs[0] == 191, "R3", "T(64)", obs[0], 191);
            if (t == 127) chk(obs[0] == 255, "R3", "T(128)", obs[0], 255);
        end
        // R5/R6: decay reaches sustain and holds
        repeat (10) burst('0, '0, 0, "", 1'b0);
        chk(obs[0] == curve(96), "R6", "ch0 sustain value", obs[0], curve(96));
        chk(obs[2] == 255, "R5", "sustain clamped to 128", obs[2], 255);
        // R9/R7: release from sustain down to idle
        burst(8'h01, 8'h01, 4, "R11", 1'b0);
        burst('0, 8'h01, 0, "", 1'b0);
        repeat (70) burst('0, '0, 0, "", 1'b0);
        chk(obs[0] == 0, "R7", "ch0 released to zero", obs[0], 0);
        // R10: gate-off on idle channel ignored, then R8 retrigger
        burst('0, 8'h01, 0, "", 1'b0);
        chk(obs[0] == 0, "R10", "idle gate-off", obs[0], 0);
        // R9: release before attack completes skips decay
        burst(8'h02, '0, 0, "", 1'b0);
        repeat (5) burst('0, '0, 0, "", 1'b0);
        burst('0, 8'h02, 0, "", 1'b0);
        repeat (3) burst('0, '0, 0, "", 1'b0);
        // R8: retrigger during release continues from current phase
        burst(8'h02, '0, 0, "", 1'b0);
        // R2: tick during a burst is ignored
        burst('0, '0, 0, "", 1'b1);
        // R11: events held for several cycles before the tick
        burst(8'h30, 8'hC0, 6, "", 1'b0);
        // Constrained random
        for (int t = 0; t < 320; t++) begin
            if (t % 40 == 0) begin
                for (int c = 0; c < NCH; c++) begin
                    rise[c] = longint'($urandom_range(32'h300000, 1));
                    fall[c] = longint'($urandom_range(32'h200000, 1));
                    fade[c] = longint'($urandom_range(32'h200000, 1));
                    hold[c] = int'($urandom_range(140, 0));
                end
                drive_params();
            end
            on_m = '0;
            off_m = '0;
            for (int c = 0; c < NCH; c++) begin
                on_m[c]  = ($urandom_range(9, 0) == 0);
                off_m[c] = ($urandom_range(7, 0) == 0);
            end
            burst(on_m, off_m, int'($urandom_range(3, 0)), "", 1'b0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule